// File: doc/BRIEF.md
# Serial Controller Host Register Bank

This block is the host-visible register file of a classic byte-wide serial controller. A host reaches eight byte registers through a 3-bit offset and single-cycle read and write strobes. It keeps the baud divisor, the framing control byte, the interrupt enables, the modem control bits and a scratch byte. It builds the line status, the modem status and the interrupt identification from its internal state. It drives one level interrupt toward the host.

Toward the serial datapath the block has two simple handshakes. On the transmit side, a data write produces a one-cycle strobe that carries the byte. On the receive side, a load strobe deposits a received byte and a break flag, and a full flag tells the datapath to hold its next byte until the host reads the current one. The divisor and the framing byte are exported for the bit-rate and shift logic. That logic and any FIFO are not part of this block.

Read data is registered: a read strobe in one cycle presents its data after the next clock edge. The interrupt output is registered from the state and follows it by one cycle.

Top module: `uart_regbank`

## Requirements
- R1: After a synchronous reset, line status reads 0x60, interrupt identification reads 0x01, modem status reads 0xB0, the divisor is 0, and both `irq` and `rx_full` are low.
- R2: While bit 7 of the line-control byte (offset 3) is set, offsets 0 and 1 read and write the low and high bytes of the 16-bit divisor. Writing offset 0 then issues no transmit strobe. The divisor appears on `divisor`.
- R3: A write to offset 1 while bit 7 of line control is clear stores only bits 3:0 of the interrupt enable, and its upper four bits read back as zero. Bit 0 enables the receive interrupt and bit 1 enables the transmit-empty interrupt.
- R4: Interrupt identification (offset 2) reads 0x04 when data is ready and enable bit 0 is set. Otherwise it reads 0x02 when the hidden transmit-empty flag is pending and enable bit 1 is set. Otherwise it reads 0x01. `irq` is high one cycle after the code differs from 0x01.
- R5: A read of offset 2 that returns 0x02 clears the hidden transmit-empty pending flag. A write to the interrupt enable while line status bit 5 is set sets that flag again.
- R6: A write to offset 0 while bit 7 of line control is clear pulses `tx_strobe` for exactly one cycle with the written byte on `tx_byte`. It leaves line status bits 5 and 6 set and the transmit-empty flag pending.
- R7: `rx_load` is accepted only while `rx_full` is low. An accepted load stores `rx_byte`, sets line status bit 0 (`rx_full`) and copies `rx_break` into line status bit 4. A load that arrives while `rx_full` is high is refused, and the stored byte is kept.
- R8: A read of offset 0 while bit 7 of line control is clear returns the stored byte and clears line status bits 0 and 4.
- R9: Modem control (offset 4) keeps bits 4:0 only. While its bit 4 is set, modem status reads as {mcr[3], mcr[2], mcr[0], mcr[1], 4'b0}. Otherwise modem status reads its fixed value 0xB0.
- R10: Writes to offsets 2, 5 and 6 change nothing. Offsets 3 and 7 read back the last byte written, and offset 3 also appears on `line_ctrl`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data, valid the cycle after `bus_rd` |
| irq | output | 1 | Level interrupt request |
| tx_strobe | output | 1 | One-cycle pulse for each byte given to the transmitter |
| tx_byte | output | 8 | Byte that goes with `tx_strobe` |
| rx_load | input | 1 | Receive datapath offers a byte |
| rx_byte | input | 8 | Offered byte |
| rx_break | input | 1 | Break condition that goes with the offered byte |
| rx_full | output | 1 | A received byte waits for the host; loads are refused while high |
| divisor | output | 16 | Baud divisor |
| line_ctrl | output | 8 | Line-control byte for the framing logic |

## Verification
The bench targets the hidden transmit-empty flag. A design that does not clear it on an identification read would keep `irq` stuck high. A design that does not re-arm it on an enable write would never raise the transmit interrupt again. The bench checks that a waiting received byte outranks transmit-empty, because a wrong priority would report 0x02 with data waiting. It loads a second byte while one is held, which catches a design that overwrites unread data. It also covers divisor-latch access that must not transmit, the loopback bit remap that a swapped bit order would break, and writes to the read-only offsets that a careless decoder would let through.

// File: rtl/uart_rb_pkg.sv
package uart_rb_pkg;
  localparam int BYTE_W   = 8;
  localparam int OFS_W    = 3;
  localparam int NUM_REGS = 1 << OFS_W;
  localparam int DIV_W    = 2 * BYTE_W;

  localparam logic [OFS_W-1:0] OFS_DATA = 3'd0;
  localparam logic [OFS_W-1:0] OFS_IER  = 3'd1;
  localparam logic [OFS_W-1:0] OFS_IIR  = 3'd2;
  localparam logic [OFS_W-1:0] OFS_LCR  = 3'd3;
  localparam logic [OFS_W-1:0] OFS_MCR  = 3'd4;
  localparam logic [OFS_W-1:0] OFS_LSR  = 3'd5;
  localparam logic [OFS_W-1:0] OFS_MSR  = 3'd6;
  localparam logic [OFS_W-1:0] OFS_SCR  = 3'd7;

  localparam logic [BYTE_W-1:0] CODE_RX   = 8'h04;
  localparam logic [BYTE_W-1:0] CODE_TX   = 8'h02;
  localparam logic [BYTE_W-1:0] CODE_IDLE = 8'h01;

  localparam int LS_READY = 0;
  localparam int LS_BREAK = 4;
  localparam int LS_HOLD  = 5;
  localparam int LS_EMPTY = 6;

  localparam int LC_DLAB  = 7;
  localparam int MC_LOOP  = 4;
endpackage

// File: rtl/uart_rb_decode.sv
module uart_rb_decode
  import uart_rb_pkg::*;
(
  input  logic [OFS_W-1:0]    addr,
  input  logic                wr,
  input  logic                rd,
  output logic [NUM_REGS-1:0] wr_sel,
  output logic [NUM_REGS-1:0] rd_sel
);
  // One select line per offset; an access hits exactly one of them.
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_sel
    assign wr_sel[i] = wr && (addr == OFS_W'(i));
    assign rd_sel[i] = rd && (addr == OFS_W'(i));
  end
endmodule

// File: rtl/uart_rb_intr.sv
module uart_rb_intr
  import uart_rb_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              data_ready,
  input  logic              en_rx,
  input  logic              en_tx,
  input  logic              hold_empty,
  input  logic              thr_wr,
  input  logic              ier_wr,
  input  logic              iir_rd,
  output logic [BYTE_W-1:0] iir_code,
  output logic              tx_pend,
  output logic              irq
);
  // Fixed priority: received data, then transmit-empty, then idle.
  always_comb begin
    if (data_ready && en_rx)      iir_code = CODE_RX;
    else if (tx_pend && en_tx)    iir_code = CODE_TX;
    else                          iir_code = CODE_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_pend <= 1'b0;
      irq     <= 1'b0;
    end else begin
      // A data write drops then re-raises the flag within the same access.
      if (thr_wr)                            tx_pend <= 1'b1;
      else if (ier_wr && hold_empty)         tx_pend <= 1'b1;
      else if (iir_rd && iir_code == CODE_TX) tx_pend <= 1'b0;
      irq <= (iir_code != CODE_IDLE);
    end
  end
endmodule

// File: rtl/uart_rb_rxtx.sv
module uart_rb_rxtx
  import uart_rb_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              thr_wr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              rbr_rd,
  input  logic              rx_load,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              rx_break,
  output logic [BYTE_W-1:0] rx_hold,
  output logic [BYTE_W-1:0] lsr,
  output logic              ready,
  output logic              tx_strobe,
  output logic [BYTE_W-1:0] tx_byte
);
  logic brk_q, hold_q, empty_q;
  logic accept;

  assign accept = rx_load && !ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_hold <= '0;
      ready   <= 1'b0;
      brk_q   <= 1'b0;
    end else if (accept) begin
      rx_hold <= rx_byte;
      ready   <= 1'b1;
      brk_q   <= rx_break;
    end else if (rbr_rd) begin
      ready   <= 1'b0;
      brk_q   <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q    <= 1'b1;
      empty_q   <= 1'b1;
      tx_strobe <= 1'b0;
      tx_byte   <= '0;
    end else begin
      tx_strobe <= thr_wr;
      if (thr_wr) begin
        tx_byte <= wdata;
        hold_q  <= 1'b1;
        empty_q <= 1'b1;
      end
    end
  end

  always_comb begin
    lsr           = '0;
    lsr[LS_READY] = ready;
    lsr[LS_BREAK] = brk_q;
    lsr[LS_HOLD]  = hold_q;
    lsr[LS_EMPTY] = empty_q;
  end
endmodule

// File: rtl/uart_rb_modem.sv
module uart_rb_modem
  import uart_rb_pkg::*;
#(
  parameter int                MCR_W    = 5,
  parameter logic [BYTE_W-1:0] MSR_INIT = 8'hB0
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              mcr_wr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] mcr_view,
  output logic [BYTE_W-1:0] msr_view
);
  logic [MCR_W-1:0]  mcr_q;
  logic [BYTE_W-1:0] msr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mcr_q <= '0;
      msr_q <= MSR_INIT;
    end else if (mcr_wr) begin
      mcr_q <= wdata[MCR_W-1:0];
    end
  end

  assign mcr_view = BYTE_W'(mcr_q);

  // Loopback ties the modem outputs back onto the status inputs.
  always_comb begin
    if (mcr_q[MC_LOOP])
      msr_view = {mcr_q[3], mcr_q[2], mcr_q[0], mcr_q[1], 4'b0000};
    else
      msr_view = msr_q;
  end
endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
  import uart_rb_pkg::*;
#(
  parameter int                IER_W    = 4,
  parameter int                MCR_W    = 5,
  parameter logic [BYTE_W-1:0] MSR_INIT = 8'hB0,
  parameter logic [DIV_W-1:0]  DIV_INIT = '0
)(
  input  logic              clk,
  input  logic              rst,
  input  logic [OFS_W-1:0]  bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic              irq,
  output logic              tx_strobe,
  output logic [BYTE_W-1:0] tx_byte,
  input  logic              rx_load,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              rx_break,
  output logic              rx_full,
  output logic [DIV_W-1:0]  divisor,
  output logic [BYTE_W-1:0] line_ctrl
);
  logic [NUM_REGS-1:0] wr_sel, rd_sel;
  logic [BYTE_W-1:0]   lcr_q, scr_q;
  logic [IER_W-1:0]    ier_q;
  logic [DIV_W-1:0]    div_q;
  logic                dlab;
  logic                thr_wr, ier_wr, rbr_rd, iir_rd;
  logic [BYTE_W-1:0]   iir_code, lsr_val, rx_hold, mcr_view, msr_view;
  logic                thr_pend;
  logic [BYTE_W-1:0]   rd_mux;

  assign dlab   = lcr_q[LC_DLAB];
  assign thr_wr = wr_sel[OFS_DATA] && !dlab;
  assign ier_wr = wr_sel[OFS_IER]  && !dlab;
  assign rbr_rd = rd_sel[OFS_DATA] && !dlab;
  assign iir_rd = rd_sel[OFS_IIR];

  uart_rb_decode u_dec (
    .addr   (bus_addr),
    .wr     (bus_wr),
    .rd     (bus_rd),
    .wr_sel (wr_sel),
    .rd_sel (rd_sel)
  );

  uart_rb_rxtx u_rxtx (
    .clk       (clk),
    .rst       (rst),
    .thr_wr    (thr_wr),
    .wdata     (bus_wdata),
    .rbr_rd    (rbr_rd),
    .rx_load   (rx_load),
    .rx_byte   (rx_byte),
    .rx_break  (rx_break),
    .rx_hold   (rx_hold),
    .lsr       (lsr_val),
    .ready     (rx_full),
    .tx_strobe (tx_strobe),
    .tx_byte   (tx_byte)
  );

  uart_rb_intr u_intr (
    .clk        (clk),
    .rst        (rst),
    .data_ready (rx_full),
    .en_rx      (ier_q[0]),
    .en_tx      (ier_q[1]),
    .hold_empty (lsr_val[LS_HOLD]),
    .thr_wr     (thr_wr),
    .ier_wr     (ier_wr),
    .iir_rd     (iir_rd),
    .iir_code   (iir_code),
    .tx_pend    (thr_pend),
    .irq        (irq)
  );

  uart_rb_modem #(.MCR_W(MCR_W), .MSR_INIT(MSR_INIT)) u_modem (
    .clk      (clk),
    .rst      (rst),
    .mcr_wr   (wr_sel[OFS_MCR]),
    .wdata    (bus_wdata),
    .mcr_view (mcr_view),
    .msr_view (msr_view)
  );

  // Host-written registers; offsets 2, 5 and 6 have no write path.
  always_ff @(posedge clk) begin
    if (rst) begin
      lcr_q <= '0;
      scr_q <= '0;
      ier_q <= '0;
      div_q <= DIV_INIT;
    end else begin
      if (wr_sel[OFS_LCR]) lcr_q <= bus_wdata;
      if (wr_sel[OFS_SCR]) scr_q <= bus_wdata;
      if (ier_wr)          ier_q <= bus_wdata[IER_W-1:0];
      if (wr_sel[OFS_DATA] && dlab) div_q[BYTE_W-1:0]     <= bus_wdata;
      if (wr_sel[OFS_IER]  && dlab) div_q[DIV_W-1:BYTE_W] <= bus_wdata;
    end
  end

  always_comb begin
    unique case (bus_addr)
      OFS_DATA: rd_mux = dlab ? div_q[BYTE_W-1:0] : rx_hold;
      OFS_IER:  rd_mux = dlab ? div_q[DIV_W-1:BYTE_W] : BYTE_W'(ier_q);
      OFS_IIR:  rd_mux = iir_code;
      OFS_LCR:  rd_mux = lcr_q;
      OFS_MCR:  rd_mux = mcr_view;
      OFS_LSR:  rd_mux = lsr_val;
      OFS_MSR:  rd_mux = msr_view;
      default:  rd_mux = scr_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  assign divisor   = div_q;
  assign line_ctrl = lcr_q;
endmodule

// File: rtl/uart_regbank_chk.sv
module uart_regbank_chk
  import uart_rb_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [OFS_W-1:0]  bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [BYTE_W-1:0] bus_wdata,
  input logic              irq,
  input logic              tx_strobe,
  input logic [BYTE_W-1:0] tx_byte,
  input logic              rx_load,
  input logic              rx_full,
  input logic [DIV_W-1:0]  divisor,
  input logic [BYTE_W-1:0] line_ctrl,
  input logic [3:0]        ier_q,
  input logic              thr_pend,
  input logic [BYTE_W-1:0] rx_hold
);
  logic dlab;
  assign dlab = line_ctrl[LC_DLAB];

  AST_TX_ISSUE: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == OFS_DATA && !dlab) |=> (tx_strobe && tx_byte == $past(bus_wdata))); // R6

  AST_TX_QUIET: assert property (@(posedge clk) disable iff (rst)
    !bus_wr |=> !tx_strobe); // R6

  AST_DIV_HIGH: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == OFS_IER && dlab) |=> (divisor[DIV_W-1:BYTE_W] == $past(bus_wdata))); // R2

  AST_IER_MASK: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == OFS_IER && !dlab) |=> (ier_q == $past(bus_wdata[3:0]))); // R3

  AST_IRQ_RX: assert property (@(posedge clk) disable iff (rst)
    (rx_full && ier_q[0]) |=> irq); // R4

  AST_IIR_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == OFS_IIR && !bus_wr && thr_pend && ier_q[1] && !(rx_full && ier_q[0]))
      |=> !thr_pend); // R5

  AST_RX_HOLD: assert property (@(posedge clk) disable iff (rst)
    (rx_full && rx_load && !(bus_rd && bus_addr == OFS_DATA && !dlab))
      |=> (rx_full && $stable(rx_hold))); // R7
endmodule

bind uart_regbank uart_regbank_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_wdata (bus_wdata),
  .irq       (irq),
  .tx_strobe (tx_strobe),
  .tx_byte   (tx_byte),
  .rx_load   (rx_load),
  .rx_full   (rx_full),
  .divisor   (divisor),
  .line_ctrl (line_ctrl),
  .ier_q     (ier_q),
  .thr_pend  (thr_pend),
  .rx_hold   (rx_hold)
);

// File: tb/tb_uart_regbank.sv
module tb_uart_regbank;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic       irq, tx_strobe, rx_full;
  logic [7:0] tx_byte, line_ctrl;
  logic       rx_load = 1'b0, rx_break = 1'b0;
  logic [7:0] rx_byte = '0;
  logic [15:0] divisor;

  always #4 clk = ~clk; // 125 MHz

  uart_regbank dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .tx_strobe(tx_strobe),
    .tx_byte(tx_byte), .rx_load(rx_load), .rx_byte(rx_byte), .rx_break(rx_break),
    .rx_full(rx_full), .divisor(divisor), .line_ctrl(line_ctrl)
  );

  int checks = 0, fails = 0;
  bit done = 1'b0;

  // Model of the register state, built from the requirements.
  logic [3:0]  m_ier = '0;
  logic [7:0]  m_lcr = '0, m_scr = '0, m_rbr = '0;
  logic [4:0]  m_mcr = '0;
  logic [15:0] m_div = '0;
  logic        m_dr = 1'b0, m_bi = 1'b0, m_pend = 1'b0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_code();
    if (m_dr && m_ier[0])        return 8'h04;
    else if (m_pend && m_ier[1]) return 8'h02;
    else                         return 8'h01;
  endfunction

  function automatic logic [7:0] exp_read(input logic [2:0] a);
    case (a)
      3'd0: return m_lcr[7] ? m_div[7:0] : m_rbr;
      3'd1: return m_lcr[7] ? m_div[15:8] : {4'h0, m_ier};
      3'd2: return exp_code();
      3'd3: return m_lcr;
      3'd4: return {3'b000, m_mcr};
      3'd5: return {1'b0, 1'b1, 1'b1, m_bi, 3'b000, m_dr};
      3'd6: return m_mcr[4] ? {m_mcr[3], m_mcr[2], m_mcr[0], m_mcr[1], 4'h0} : 8'hB0;
      default: return m_scr;
    endcase
  endfunction

  task automatic chk_irq(input string req);
    @(negedge clk);
    check(req, irq, exp_code() != 8'h01);
  endtask

  task automatic op_write(input logic [2:0] a, input logic [7:0] d);
    bit is_thr;
    is_thr = (a == 3'd0) && !m_lcr[7];
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    case (a)
      3'd0: if (m_lcr[7]) m_div[7:0] = d; else m_pend = 1'b1;
      3'd1: if (m_lcr[7]) m_div[15:8] = d; else begin m_ier = d[3:0]; m_pend = 1'b1; end
      3'd3: m_lcr = d;
      3'd4: m_mcr = d[4:0];
      3'd7: m_scr = d;
      default: ;
    endcase
    check("R6 tx_strobe on write", tx_strobe, is_thr);
    if (is_thr) check("R6 tx_byte", tx_byte, d);
    chk_irq("R4 irq after write");
    check("R6 tx_strobe single pulse", tx_strobe, 1'b0);
  endtask

  task automatic op_read(input logic [2:0] a, input string req);
    logic [7:0] expv;
    expv = exp_read(a);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    check(req, bus_rdata, expv);
    if (a == 3'd0 && !m_lcr[7]) begin m_dr = 1'b0; m_bi = 1'b0; end
    if (a == 3'd2 && expv == 8'h02) m_pend = 1'b0;
    chk_irq("R4 irq after read");
  endtask

  task automatic op_rx(input logic [7:0] b, input logic brk);
    rx_byte = b; rx_break = brk; rx_load = 1'b1;
    @(negedge clk);
    rx_load = 1'b0;
    if (!m_dr) begin m_rbr = b; m_bi = brk; m_dr = 1'b1; end
    check("R7 rx_full after load", rx_full, m_dr);
    chk_irq("R4 irq after load");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd24680);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 irq at reset", irq, 1'b0);
    check("R1 rx_full at reset", rx_full, 1'b0);
    check("R1 divisor at reset", divisor, 16'h0000);
    op_read(3'd5, "R1 LSR reset 0x60");
    op_read(3'd2, "R1 IIR reset 0x01");
    op_read(3'd6, "R1 MSR reset 0xB0");

    // R10 ignored writes and readback
    op_write(3'd5, 8'hFF); op_read(3'd5, "R10 LSR unchanged by write");
    op_write(3'd6, 8'h00); op_read(3'd6, "R10 MSR unchanged by write");
    op_write(3'd2, 8'hFF); op_read(3'd2, "R10 IIR unchanged by write");
    op_write(3'd7, 8'hA5); op_read(3'd7, "R10 scratch readback");
    check("R10 scratch literal", bus_rdata, 8'hA5);

    // R3 / R5 enable mask and transmit-empty flag
    op_write(3'd1, 8'hFF); op_read(3'd1, "R3 IER masked to 0x0F");
    check("R3 IER literal", bus_rdata, 8'h0F);
    op_read(3'd2, "R5 IIR shows 0x02 after IER write");
    check("R5 IIR literal 0x02", bus_rdata, 8'h02);
    op_read(3'd2, "R5 IIR 0x01 after clearing read");
    check("R5 irq low after clear", irq, 1'b0);

    // R6 transmit
    op_write(3'd0, 8'h3C);
    op_read(3'd5, "R6 LSR after data write");
    op_read(3'd2, "R6 pending after data write");

    // R7 / R8 / R4 receive, priority, refusal
    op_rx(8'h5A, 1'b1);
    op_write(3'd1, 8'h03);
    op_read(3'd2, "R4 receive outranks transmit");
    check("R4 IIR literal 0x04", bus_rdata, 8'h04);
    op_read(3'd5, "R7 LSR with break 0x71");
    check("R7 LSR literal", bus_rdata, 8'h71);
    op_rx(8'h99, 1'b0);
    op_read(3'd0, "R8 held byte survives refused load");
    check("R8 byte literal", bus_rdata, 8'h5A);
    check("R8 rx_full cleared", rx_full, 1'b0);
    op_read(3'd5, "R8 LSR cleared bits 0 and 4");

    // R2 divisor latch
    op_write(3'd3, 8'h83);
    op_write(3'd0, 8'h34);
    op_write(3'd1, 8'h12);
    check("R2 divisor output", divisor, 16'h1234);
    op_read(3'd0, "R2 divisor low read");
    op_read(3'd1, "R2 divisor high read");
    op_write(3'd3, 8'h03);
    check("R10 line_ctrl output", line_ctrl, 8'h03);
    op_read(3'd1, "R2 IER visible again");

    // R9 modem control and loopback
    op_write(3'd4, 8'hFF); op_read(3'd4, "R9 MCR masked 0x1F");
    op_read(3'd6, "R9 loopback all ones 0xF0");
    check("R9 loopback literal", bus_rdata, 8'hF0);
    op_write(3'd4, 8'h15); op_read(3'd6, "R9 loopback 0x60");
    check("R9 loopback literal 2", bus_rdata, 8'h60);
    op_write(3'd4, 8'h0A); op_read(3'd6, "R9 no loopback 0xB0");

    // Random mix checked against the model
    for (int i = 0; i < 400; i++) begin
      logic [2:0] a;
      logic [7:0] d;
      int kind;
      a = 3'($urandom % 8);
      d = 8'($urandom);
      kind = int'($urandom % 4);
      if (kind == 0)      op_write(a, d);
      else if (kind == 1) op_rx(d, d[0]);
      else                op_read(a, "R4 R8 R9 random read");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule